// File: doc/BRIEF.md
# LCD Display Timing Generator

The block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, a data-enable strobe and the zero-based column and row of the pixel currently being presented. Sync widths, back porches, front porches and the active area are loaded through a simple register write port. Each timing field holds its count minus one. A pixel-clock enable is derived from the source clock, either 1:1 or divided by a programmable ratio.

The pixel-clock divider and one of the two video-enable bits are frame-synchronised. While video runs, a write to these fields lands in a written copy. The active copy picks it up only when the raster wraps back to the start of vertical sync, so a frame never mixes two settings. While video is stopped, the active copy follows the written copy one cycle later.

A frame interrupt can be armed to fire on the rising edge of vertical sync. The pending bit stays set until software writes a 1 to it. Sync polarity is chosen per output by a separate register.

Top module: `lcd_tgen_top`

## Requirements
- R1: After synchronous reset, every register reads as zero, video is stopped, hsync and vsync are 0, de is 0, pix_x and pix_y are 0, and irq is 0.
- R2: Each line is laid out as hsync for HSW+1 pixels, then back porch for HBP+1, then active for HACT+1, then front porch for HFP+1. HSW, HBP and HFP sit at register 2 bits [7:0], [15:8] and [23:16]. HACT sits at register 4 bits [10:0].
- R3: Each frame follows the same order counted in lines: vsync for VSW+1 lines, then back porch VBP+1, then active VACT+1, then front porch VFP+1. VSW, VBP and VFP sit at register 3 with the same bit positions as register 2. VACT sits at register 4 bits [26:16]. The line counter advances on the last pixel of each line.
- R4: de is 1 only when both counters are inside their active regions. pix_x and pix_y then give the offset from the first active pixel and line. Both coordinates are 0 whenever de is 0.
- R5: With the divide-select bit (register 0 bit 2) clear, one pixel is presented per source clock. With it set, one pixel is presented every DIV+1 source clocks, where DIV is register 0 bits [15:8].
- R6: While video runs, the divide-select bit, DIV and the frame-synchronised enable (register 0 bit 1) take a newly written value only after the last pixel of the last line of a frame. While video is stopped, they take it on the following cycle.
- R7: Video runs only while both the immediate enable (register 0 bit 0) and the active copy of the frame-synchronised enable are 1. Clearing the immediate enable stops output on the next cycle and returns both counters to the first sync pixel.
- R8: Register 1 bit 0 inverts hsync and bit 1 inverts vsync, including while stopped.
- R9: When the interrupt enable (register 5 bit 0) is 1, a rise of the internal vertical sync sets the pending bit one cycle later. irq shows the pending bit. A set has priority over a clear in the same cycle.
- R10: Writing 1 to register 6 bit 0 clears the pending bit. Writing 0 there, or writing any unused address, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable |
| pix_x | output | 11 | Active column, zero outside active area |
| pix_y | output | 11 | Active row, zero outside active area |
| irq | output | 1 | Frame interrupt pending |

## Verification
A register write is captured on the edge where wr_en is high. The write of both enable bits takes a second edge before video runs, because the frame-synchronised copy loads one cycle after the written copy. The raster outputs are decoded from registered counters, so they change in the cycle after the edge that moves the counters. irq follows a vsync rise by one edge. The bench steps a behavioural model on the same edges and compares every output at the falling edge of each cycle, so each delay above is checked exactly rather than within a window.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int PORCH_W = 8;
    localparam int SIZE_W  = 11;
    localparam int DIV_W   = 8;
    localparam int CNT_W   = SIZE_W + 2;

    // field positions inside the write data
    localparam int F_SW_LSB   = 0;
    localparam int F_BP_LSB   = 8;
    localparam int F_FP_LSB   = 16;
    localparam int F_HACT_LSB = 0;
    localparam int F_VACT_LSB = 16;
    localparam int F_DIV_LSB  = 8;
    localparam int F_USED_MSB = 26;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_POL   = 3'd1,
        REG_HTIM  = 3'd2,
        REG_VTIM  = 3'd3,
        REG_SIZE  = 3'd4,
        REG_IEN   = 3'd5,
        REG_ISTAT = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [PORCH_W-1:0] fp;
        logic [PORCH_W-1:0] bp;
        logic [PORCH_W-1:0] sw;
    } axis_tim_t;

    typedef struct packed {
        logic             frame_en;
        logic             div_sel;
        logic [DIV_W-1:0] div;
    } sync_fields_t;

    typedef struct packed {
        logic [CNT_W-1:0] sync_end;
        logic [CNT_W-1:0] act_start;
        logic [CNT_W-1:0] act_end;
        logic [CNT_W-1:0] total;
    } axis_bounds_t;

    function automatic axis_bounds_t calc_bounds(axis_tim_t t, logic [SIZE_W-1:0] act);
        axis_bounds_t b;
        b.sync_end  = CNT_W'(t.sw) + CNT_W'(1);
        b.act_start = b.sync_end + CNT_W'(t.bp) + CNT_W'(1);
        b.act_end   = b.act_start + CNT_W'(act) + CNT_W'(1);
        b.total     = b.act_end + CNT_W'(t.fp) + CNT_W'(1);
        return b;
    endfunction

endpackage

// File: rtl/lcd_tgen_regs.sv
module lcd_tgen_regs
    import lcd_tgen_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                frame_wrap,
    input  logic                vs_rise,
    output logic                run,
    output sync_fields_t        act_sync,
    output axis_tim_t           htim,
    output axis_tim_t           vtim,
    output logic [SIZE_W-1:0]   hact,
    output logic [SIZE_W-1:0]   vact,
    output logic [1:0]          pol,
    output logic                irq_pend
);

    sync_fields_t wr_sync;
    logic         imm_en;
    logic         ien;
    logic         clr_req;
    logic         unused_bits;

    assign unused_bits = ^wr_data[DATA_W-1:F_USED_MSB+1];
    assign run     = imm_en & act_sync.frame_en;
    assign clr_req = wr_en && (wr_addr == REG_ISTAT) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_sync  <= '0;
            act_sync <= '0;
            imm_en   <= 1'b0;
            htim     <= '0;
            vtim     <= '0;
            hact     <= '0;
            vact     <= '0;
            pol      <= '0;
            ien      <= 1'b0;
            irq_pend <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    REG_CTRL: begin
                        imm_en           <= wr_data[0];
                        wr_sync.frame_en <= wr_data[1];
                        wr_sync.div_sel  <= wr_data[2];
                        wr_sync.div      <= wr_data[F_DIV_LSB +: DIV_W];
                    end
                    REG_POL:  pol <= wr_data[1:0];
                    REG_HTIM: begin
                        htim.sw <= wr_data[F_SW_LSB +: PORCH_W];
                        htim.bp <= wr_data[F_BP_LSB +: PORCH_W];
                        htim.fp <= wr_data[F_FP_LSB +: PORCH_W];
                    end
                    REG_VTIM: begin
                        vtim.sw <= wr_data[F_SW_LSB +: PORCH_W];
                        vtim.bp <= wr_data[F_BP_LSB +: PORCH_W];
                        vtim.fp <= wr_data[F_FP_LSB +: PORCH_W];
                    end
                    REG_SIZE: begin
                        hact <= wr_data[F_HACT_LSB +: SIZE_W];
                        vact <= wr_data[F_VACT_LSB +: SIZE_W];
                    end
                    REG_IEN:  ien <= wr_data[0];
                    default:  ;
                endcase
            end
            // frame-synchronised copy: follows while stopped, at frame wrap while running
            if (!run || frame_wrap)
                act_sync <= wr_sync;
            if (ien && vs_rise)
                irq_pend <= 1'b1;
            else if (clr_req)
                irq_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/lcd_tgen_pixdiv.sv
module lcd_tgen_pixdiv
    import lcd_tgen_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          div_sel,
    input  logic [DW-1:0] div,
    output logic          pix_en
);

    logic [DW-1:0] cnt;
    logic          hit;

    assign hit    = (cnt == div);
    assign pix_en = run && (!div_sel || hit);

    always_ff @(posedge clk) begin
        if (rst || !run || !div_sel)
            cnt <= '0;
        else if (hit)
            cnt <= '0;
        else
            cnt <= cnt + DW'(1);
    end

endmodule

// File: rtl/lcd_tgen_axis.sv
module lcd_tgen_axis
    import lcd_tgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    input  axis_bounds_t      bnd,
    output logic              at_end,
    output logic              in_sync,
    output logic              in_act,
    output logic [SIZE_W-1:0] pos
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rel;

    assign at_end  = (cnt >= bnd.total - CNT_W'(1));
    assign in_sync = (cnt < bnd.sync_end);
    assign in_act  = (cnt >= bnd.act_start) && (cnt < bnd.act_end);
    assign rel     = cnt - bnd.act_start;
    assign pos     = rel[SIZE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (adv)
            cnt <= at_end ? '0 : cnt + CNT_W'(1);
    end

endmodule

// File: rtl/lcd_tgen_top.sv
module lcd_tgen_top
    import lcd_tgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [10:0]       pix_x,
    output logic [10:0]       pix_y,
    output logic              irq
);

    localparam int N_AXES = 2;

    logic              run;
    sync_fields_t      act_sync;
    axis_tim_t         htim, vtim;
    logic [SIZE_W-1:0] hact, vact;
    logic [1:0]        pol;
    logic              pix_en;
    logic              frame_wrap;
    logic              vs_raw, vs_q, vs_rise;

    axis_bounds_t      ax_bnd [N_AXES];
    logic [N_AXES-1:0] ax_adv, ax_end, ax_sync, ax_act;
    logic [SIZE_W-1:0] ax_pos [N_AXES];

    lcd_tgen_regs u_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_wrap(frame_wrap), .vs_rise(vs_rise),
        .run(run), .act_sync(act_sync),
        .htim(htim), .vtim(vtim), .hact(hact), .vact(vact),
        .pol(pol), .irq_pend(irq)
    );

    lcd_tgen_pixdiv #(.DW(DIV_W)) u_div (
        .clk(clk), .rst(rst), .run(run),
        .div_sel(act_sync.div_sel), .div(act_sync.div),
        .pix_en(pix_en)
    );

    assign ax_bnd[0] = calc_bounds(htim, hact);
    assign ax_bnd[1] = calc_bounds(vtim, vact);
    assign ax_adv[0] = pix_en;
    assign ax_adv[1] = pix_en & ax_end[0];

    for (genvar g = 0; g < N_AXES; g++) begin : g_axis
        lcd_tgen_axis u_axis (
            .clk(clk), .rst(rst), .clr(!run), .adv(ax_adv[g]),
            .bnd(ax_bnd[g]),
            .at_end(ax_end[g]), .in_sync(ax_sync[g]),
            .in_act(ax_act[g]), .pos(ax_pos[g])
        );
    end

    assign frame_wrap = pix_en & ax_end[0] & ax_end[1];
    assign vs_raw     = run & ax_sync[1];
    assign vs_rise    = vs_raw & !vs_q;

    always_ff @(posedge clk) begin
        if (rst) vs_q <= 1'b0;
        else     vs_q <= vs_raw;
    end

    assign de    = run & ax_act[0] & ax_act[1];
    assign hsync = (run & ax_sync[0]) ^ pol[0];
    assign vsync = vs_raw ^ pol[1];
    assign pix_x = de ? ax_pos[0] : '0;
    assign pix_y = de ? ax_pos[1] : '0;

endmodule

// File: rtl/lcd_tgen_chk.sv
module lcd_tgen_chk (
    input logic        clk,
    input logic        rst,
    input logic        hsync,
    input logic        vsync,
    input logic        de,
    input logic [10:0] pix_x,
    input logic [10:0] pix_y,
    input logic        irq,
    input logic        run,
    input logic        vs_rise,
    input logic [1:0]  pol,
    input logic        clr_req
);

    a_r4_coords_zero: assert property (@(posedge clk) disable iff (rst)
        !de |-> (pix_x == 11'd0 && pix_y == 11'd0));

    a_r4_de_outside_hsync: assert property (@(posedge clk) disable iff (rst)
        de |-> (hsync == pol[0]));

    a_r7_idle_when_stopped: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!de && hsync == pol[0] && vsync == pol[1]));

    a_r9_pend_holds: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr_req) |=> irq);

    a_r9_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (!irq && !vs_rise) |=> !irq);

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !vs_rise) |=> !irq);

endmodule

bind lcd_tgen_top lcd_tgen_chk u_chk (
    .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .irq(irq), .run(run),
    .vs_rise(vs_rise), .pol(pol),
    .clr_req(wr_en && (wr_addr == 3'd6) && wr_data[0])
);

// File: tb/lcd_tgen_top_tb_top.sv
module lcd_tgen_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, de, irq;
    logic [10:0] pix_x, pix_y;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    started = 0;

    always #4 clk = ~clk;

    lcd_tgen_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y), .irq(irq)
    );

    // behavioural reference state
    int m_hsw, m_hbp, m_hfp, m_hact, m_vsw, m_vbp, m_vfp, m_vact;
    int m_ven, m_wf, m_wsel, m_wdiv, m_af, m_asel, m_adiv;
    int m_polh, m_polv, m_ien, m_pend, m_vsq, m_dc, m_h, m_v;

    function automatic int htot(); return m_hsw + m_hbp + m_hact + m_hfp + 4; endfunction
    function automatic int vtot(); return m_vsw + m_vbp + m_vact + m_vfp + 4; endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_hsw = 0; m_hbp = 0; m_hfp = 0; m_hact = 0;
            m_vsw = 0; m_vbp = 0; m_vfp = 0; m_vact = 0;
            m_ven = 0; m_wf = 0; m_wsel = 0; m_wdiv = 0; m_af = 0; m_asel = 0; m_adiv = 0;
            m_polh = 0; m_polv = 0; m_ien = 0; m_pend = 0; m_vsq = 0; m_dc = 0; m_h = 0; m_v = 0;
        end else begin
            bit run, pix, hend, vend, fw, vsr, rise;
            run  = (m_ven != 0) && (m_af != 0);
            pix  = run && (m_asel == 0 || m_dc == m_adiv);
            hend = m_h >= htot() - 1;
            vend = m_v >= vtot() - 1;
            fw   = pix && hend && vend;
            vsr  = run && (m_v < m_vsw + 1);
            rise = vsr && (m_vsq == 0);
            if (m_ien != 0 && rise) m_pend = 1;
            else if (wr_en && wr_addr == 3'd6 && wr_data[0]) m_pend = 0;
            m_vsq = vsr;
            if (!run || m_asel == 0) m_dc = 0;
            else m_dc = (m_dc == m_adiv) ? 0 : m_dc + 1;
            if (!run) begin m_h = 0; m_v = 0; end
            else if (pix) begin
                if (hend) begin m_h = 0; m_v = vend ? 0 : m_v + 1; end
                else m_h = m_h + 1;
            end
            if (!run || fw) begin m_af = m_wf; m_asel = m_wsel; m_adiv = m_wdiv; end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_ven = wr_data[0]; m_wf = wr_data[1]; m_wsel = wr_data[2]; m_wdiv = wr_data[15:8]; end
                    3'd1: begin m_polh = wr_data[0]; m_polv = wr_data[1]; end
                    3'd2: begin m_hsw = wr_data[7:0]; m_hbp = wr_data[15:8]; m_hfp = wr_data[23:16]; end
                    3'd3: begin m_vsw = wr_data[7:0]; m_vbp = wr_data[15:8]; m_vfp = wr_data[23:16]; end
                    3'd4: begin m_hact = wr_data[10:0]; m_vact = wr_data[26:16]; end
                    3'd5: m_ien = wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string sig, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d exp %0d", cur_req, sig, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            bit run, hs, vs, de_e;
            int has, vas;
            run  = (m_ven != 0) && (m_af != 0);
            has  = m_hsw + m_hbp + 2;
            vas  = m_vsw + m_vbp + 2;
            hs   = run && (m_h < m_hsw + 1);
            vs   = run && (m_v < m_vsw + 1);
            de_e = run && m_h >= has && m_h < has + m_hact + 1 && m_v >= vas && m_v < vas + m_vact + 1;
            chk("hsync", hsync, hs ^ m_polh[0]);
            chk("vsync", vsync, vs ^ m_polv[0]);
            chk("de", de, de_e);
            chk("pix_x", pix_x, de_e ? m_h - has : 0);
            chk("pix_y", pix_y, de_e ? m_v - vas : 0);
            chk("irq", irq, m_pend);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL %s watchdog got 0 exp 1", cur_req);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        started = 1;
        cur_req = "R1";
        chk("reset_de", de, 0);
        chk("reset_irq", irq, 0);
        idle(5);

        cur_req = "R10";
        wr(3'd2, {8'd0, 8'd1, 8'd2, 8'd1});       // hsw 2, hbp 3, hfp 2
        wr(3'd3, {8'd0, 8'd0, 8'd1, 8'd0});       // vsw 1, vbp 2, vfp 1
        wr(3'd4, {5'd0, 11'd3, 5'd0, 11'd7});     // 8 x 4 active
        wr(3'd7, 32'hFFFF_FFFF);                  // unused address
        idle(5);

        cur_req = "R7";                           // immediate enable only: no output
        wr(3'd0, 32'h1);
        idle(20);

        cur_req = "R2 R3 R4";
        wr(3'd0, 32'h3);
        idle(260);

        cur_req = "R9";
        wr(3'd5, 32'h1);
        idle(130);
        cur_req = "R10";
        wr(3'd6, 32'h0);
        idle(3);
        wr(3'd6, 32'h1);
        idle(20);

        cur_req = "R6";                           // divider written mid-frame
        wr(3'd0, 32'h0000_0207);
        idle(400);

        cur_req = "R5";
        idle(400);

        cur_req = "R8";
        wr(3'd1, 32'h3);
        idle(100);

        cur_req = "R6";                           // frame-sync enable cleared: stops at frame end
        wr(3'd0, 32'h0000_0205);
        idle(400);

        cur_req = "R5";                           // restart in 1:1 mode
        wr(3'd0, 32'h3);
        idle(150);

        cur_req = "R7";                           // immediate stop
        wr(3'd0, 32'h2);
        idle(30);

        finish_run();
    end

endmodule